// File: doc/BRIEF.md
# Serial EEPROM Register Emulator

This block stands in for a small serial EEPROM that holds 16-bit words. The host reaches it only through two 32-bit registers on a simple synchronous strobe bus. The first register is a bit-bang port. The host writes a clock bit, a select bit, a data-in bit and an access request. It reads back the data-out bit and an access grant. A read transaction is an 8-bit opcode followed by a 16-bit byte address, both shifted in most significant bit first. The 16 bits of the addressed word then come back one per rising clock write.

The second register is a one-shot lookup. Writing a word index with the start flag set returns that word and a done flag on the next read. The contents of the word array are fixed. They are computed from the `SEED` and `DEPTH` parameters and need no storage.

The register bus never stalls. Every write strobe is accepted in its own cycle. Every read strobe is answered exactly one cycle later with `rd_valid`, so a host needs no back-pressure handling.

Top module: `eeprom_emu`

## Requirements
- R1: After reset, both registers read as zero.
- R2: A read strobe (`rd_sel` 0 = bit-bang register, 1 = lookup register) returns `rd_valid` and `rd_data` on the next cycle, and `rd_valid` is never high otherwise. A read reflects every write accepted in an earlier cycle.
- R3: In the bit-bang register, bit 0 is the clock, bit 1 is the select, bit 2 is data-in, bit 3 is data-out (read only), bit 4 is the request and bit 5 is the grant (read only). Data-in is sampled only when a write has select at 1 and moves the clock bit from 0 to 1; any other write leaves data-out unchanged.
- R4: The first 8 sampled bits form the opcode and the next 16 form the byte address, each most significant bit first.
- R5: Rising edges 25 to 40 present bits 15 down to 0 of word index (address / 2) on data-out, but only when the opcode is 0x03. Any other opcode, an index at or above `DEPTH`, and every edge after the 40th give 0.
- R6: Data-out reads 0 whenever read data is not being shifted: with select low, and during the opcode and address phases.
- R7: A write with select at 0 returns the opcode, the address and the bit count to idle, so the next transaction starts cleanly.
- R8: The grant bit always reads equal to the request bit last written.
- R9: In the lookup register, bit 0 is start (always reads 0), bit 1 is done (read only), bits [15:8] are the word index and bits [31:16] are the data (read only). A write with start at 1 loads the word at the index into data and sets done. An index at or above `DEPTH` loads 0 and still sets done.
- R10: A write to the lookup register with start at 0 stores the index, clears done and keeps the data field.
- R11: Word i (for i < `DEPTH`) equals the low 16 bits of (i × 0x0101) XOR `SEED`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 1 | Write target: 0 bit-bang, 1 lookup |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_sel | input | 1 | Read target: 0 bit-bang, 1 lookup |
| rd_valid | output | 1 | Read data is valid this cycle |
| rd_data | output | 32 | Read data |

## Verification
Every register effect lands in the cycle after its write strobe. A read issued after that write returns its value one cycle after the read strobe. The bench therefore advances a behavioural model at each rising edge from the inputs driven there. It compares `rd_valid` and `rd_data` at the following falling edge, on every cycle. Serial words are checked as a whole once all sixteen data-out samples have arrived, one per clock-raising write. Every data-out sample is read back in the cycle after the write that produced it.

// File: rtl/eeprom_emu_pkg.sv
package eeprom_emu_pkg;
  localparam int WORD_W = 16;
  localparam int OP_W   = 8;
  localparam int BADR_W = 16;
  localparam logic [OP_W-1:0] OP_READ = 8'h03;

  // bit-bang register fields
  localparam int F_SCLK = 0;
  localparam int F_CS   = 1;
  localparam int F_SDI  = 2;
  localparam int F_SDO  = 3;
  localparam int F_REQ  = 4;
  localparam int F_GNT  = 5;

  // lookup register fields
  localparam int F_START = 0;
  localparam int F_DONE  = 1;
  localparam int F_IDX   = 8;
  localparam int F_DATA  = 16;

  function automatic logic [WORD_W-1:0] word_at(logic [31:0] idx,
                                                logic [WORD_W-1:0] seed,
                                                int unsigned depth);
    logic [31:0] prod;
    if (idx >= depth) return '0;
    prod = idx * 32'd257;
    return prod[WORD_W-1:0] ^ seed;
  endfunction
endpackage

// File: rtl/eeprom_words.sv
module eeprom_words
  import eeprom_emu_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  parameter logic [WORD_W-1:0] SEED = 16'hA5C3,
  parameter int unsigned NPORT = 2,
  parameter int unsigned IW = 15
) (
  input  logic [NPORT-1:0][IW-1:0]     idx,
  output logic [NPORT-1:0][WORD_W-1:0] word
);
  for (genvar p = 0; p < NPORT; p++) begin : g_port
    assign word[p] = word_at(32'(idx[p]), SEED, DEPTH);
  end
endmodule

// File: rtl/eeprom_serial.sv
module eeprom_serial
  import eeprom_emu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              w_sclk,
  input  logic              w_cs,
  input  logic              w_sdi,
  input  logic              w_req,
  output logic [BADR_W-2:0] word_idx,
  input  logic [WORD_W-1:0] word,
  output logic              sclk,
  output logic              cs,
  output logic              sdi,
  output logic              sdo,
  output logic              req
);
  localparam int HDR_N  = OP_W + BADR_W;
  localparam int HCNT_W = $clog2(HDR_N + 1);
  localparam int DCNT_W = $clog2(WORD_W + 1);
  localparam logic [HCNT_W-1:0] OP_END  = HCNT_W'(OP_W);
  localparam logic [HCNT_W-1:0] HDR_END = HCNT_W'(HDR_N);
  localparam logic [DCNT_W-1:0] DAT_END = DCNT_W'(WORD_W);

  logic [HCNT_W-1:0] hdr_cnt;
  logic [DCNT_W-1:0] dat_cnt;
  logic [OP_W-1:0]   op_q;
  logic [BADR_W-1:0] adr_q;
  logic              rise;
  logic [DCNT_W-1:0] bit_sel;

  assign rise     = wr && w_cs && !sclk && w_sclk;
  assign word_idx = adr_q[BADR_W-1:1];
  assign bit_sel  = DAT_END - 1'b1 - dat_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk <= 1'b0; cs <= 1'b0; sdi <= 1'b0; req <= 1'b0; sdo <= 1'b0;
      hdr_cnt <= '0; dat_cnt <= '0; op_q <= '0; adr_q <= '0;
    end else if (wr) begin
      sclk <= w_sclk; cs <= w_cs; sdi <= w_sdi; req <= w_req;
      if (!w_cs) begin
        hdr_cnt <= '0; dat_cnt <= '0; op_q <= '0; adr_q <= '0; sdo <= 1'b0;
      end else if (rise) begin
        if (hdr_cnt < OP_END) begin
          op_q    <= {op_q[OP_W-2:0], w_sdi};
          hdr_cnt <= hdr_cnt + 1'b1;
          sdo     <= 1'b0;
        end else if (hdr_cnt < HDR_END) begin
          adr_q   <= {adr_q[BADR_W-2:0], w_sdi};
          hdr_cnt <= hdr_cnt + 1'b1;
          sdo     <= 1'b0;
        end else if (dat_cnt < DAT_END) begin
          sdo     <= (op_q == OP_READ) ? word[bit_sel[$clog2(WORD_W)-1:0]] : 1'b0;
          dat_cnt <= dat_cnt + 1'b1;
        end else begin
          sdo <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/eeprom_direct.sv
module eeprom_direct
  import eeprom_emu_pkg::*;
#(
  parameter int unsigned DR_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              w_start,
  input  logic [DR_AW-1:0]  w_idx,
  input  logic [WORD_W-1:0] word,
  output logic              done,
  output logic [DR_AW-1:0]  idx,
  output logic [WORD_W-1:0] data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done <= 1'b0; idx <= '0; data <= '0;
    end else if (wr) begin
      idx <= w_idx;
      if (w_start) begin
        data <= word;
        done <= 1'b1;
      end else begin
        done <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/eeprom_emu.sv
module eeprom_emu
  import eeprom_emu_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  parameter logic [15:0] SEED  = 16'hA5C3,
  parameter int unsigned DR_AW = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        wr_sel,
  input  logic [31:0] wr_data,
  input  logic        rd_en,
  input  logic        rd_sel,
  output logic        rd_valid,
  output logic [31:0] rd_data
);
  localparam int IW = BADR_W - 1;

  logic [1:0][IW-1:0]     w_idx;
  logic [1:0][WORD_W-1:0] w_word;
  logic [IW-1:0]          ser_idx;
  logic ser_sclk, ser_cs, ser_sdi, ser_sdo, ser_req, ser_gnt;
  logic                   dr_done;
  logic [DR_AW-1:0]       dr_idx;
  logic [WORD_W-1:0]      dr_data;
  logic [DR_AW-1:0]       wr_idx;
  logic [31:0]            rd_mux;

  assign wr_idx   = wr_data[F_IDX +: DR_AW];
  assign w_idx[0] = ser_idx;
  assign w_idx[1] = IW'(wr_idx);
  assign ser_gnt  = ser_req;

  eeprom_words #(.DEPTH(DEPTH), .SEED(SEED), .NPORT(2), .IW(IW)) u_words (
    .idx(w_idx), .word(w_word)
  );

  eeprom_serial u_serial (
    .clk(clk), .rst_n(rst_n), .wr(wr_en && !wr_sel),
    .w_sclk(wr_data[F_SCLK]), .w_cs(wr_data[F_CS]),
    .w_sdi(wr_data[F_SDI]), .w_req(wr_data[F_REQ]),
    .word_idx(ser_idx), .word(w_word[0]),
    .sclk(ser_sclk), .cs(ser_cs), .sdi(ser_sdi), .sdo(ser_sdo), .req(ser_req)
  );

  eeprom_direct #(.DR_AW(DR_AW)) u_direct (
    .clk(clk), .rst_n(rst_n), .wr(wr_en && wr_sel),
    .w_start(wr_data[F_START]), .w_idx(wr_idx), .word(w_word[1]),
    .done(dr_done), .idx(dr_idx), .data(dr_data)
  );

  always_comb begin
    rd_mux = '0;
    if (rd_sel) begin
      rd_mux[F_DONE]             = dr_done;
      rd_mux[F_IDX +: DR_AW]     = dr_idx;
      rd_mux[F_DATA +: WORD_W]   = dr_data;
    end else begin
      rd_mux[F_SCLK] = ser_sclk;
      rd_mux[F_CS]   = ser_cs;
      rd_mux[F_SDI]  = ser_sdi;
      rd_mux[F_SDO]  = ser_sdo;
      rd_mux[F_REQ]  = ser_req;
      rd_mux[F_GNT]  = ser_gnt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_mux;
    end
  end
endmodule

// File: rtl/eeprom_emu_chk.sv
module eeprom_emu_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        wr_sel,
  input logic [31:0] wr_data,
  input logic        rd_en,
  input logic        rd_sel,
  input logic        rd_valid,
  input logic [31:0] rd_data,
  input logic        ser_cs,
  input logic        ser_sdo,
  input logic        dr_done
);
  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid); // R2
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid); // R2
  AST_GNT_MIRRORS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && $past(!rd_sel) |-> rd_data[5] == rd_data[4]); // R8
  AST_START_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && $past(rd_sel) |-> !rd_data[0]); // R9
  AST_DONE_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_sel && wr_data[0] |=> dr_done); // R9
  AST_DONE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_sel && !wr_data[0] |=> !dr_done); // R10
  AST_SDO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_cs |-> !ser_sdo); // R6
  AST_SDO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && !wr_sel) |=> $stable(ser_sdo)); // R3
  AST_CS_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !wr_sel && !wr_data[1] |=> !ser_sdo); // R7
endmodule

bind eeprom_emu eeprom_emu_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .rd_en(rd_en), .rd_sel(rd_sel), .rd_valid(rd_valid), .rd_data(rd_data),
  .ser_cs(ser_cs), .ser_sdo(ser_sdo), .dr_done(dr_done)
);

// File: tb/eeprom_emu_tb.sv
module eeprom_emu_tb;
  localparam int DEPTH = 64;
  localparam logic [15:0] SEED = 16'hA5C3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, wr_sel = 1'b0, rd_en = 1'b0, rd_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic rd_valid;
  logic [31:0] rd_data;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;
  string tag = "R1";

  always #2 clk = ~clk;

  eeprom_emu u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_en(rd_en), .rd_sel(rd_sel), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  function automatic int ref_word(int i);
    if (i < 0 || i >= DEPTH) return 0;
    return ((i * 257) & 16'hFFFF) ^ int'(SEED); // R11
  endfunction

  // behavioural reference model
  int m_sclk, m_cs, m_sdi, m_req, m_sdo, m_op, m_adr, m_nbits;
  int m_didx, m_ddata, m_done;
  bit exp_valid;
  logic [31:0] exp_data;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sclk = 0; m_cs = 0; m_sdi = 0; m_req = 0; m_sdo = 0;
      m_op = 0; m_adr = 0; m_nbits = 0; m_didx = 0; m_ddata = 0; m_done = 0;
      exp_valid = 0; exp_data = '0;
    end else begin
      exp_valid = rd_en;
      if (rd_en) begin
        exp_data = '0;
        if (rd_sel) begin
          exp_data[31:16] = m_ddata[15:0];
          exp_data[15:8]  = m_didx[7:0];
          exp_data[1]     = m_done[0];
        end else begin
          exp_data[0] = m_sclk[0]; exp_data[1] = m_cs[0]; exp_data[2] = m_sdi[0];
          exp_data[3] = m_sdo[0];  exp_data[4] = m_req[0]; exp_data[5] = m_req[0];
        end
      end
      if (wr_en && !wr_sel) begin
        if (!wr_data[1]) begin
          m_op = 0; m_adr = 0; m_nbits = 0; m_sdo = 0;
        end else if (m_sclk == 0 && wr_data[0]) begin
          m_nbits++;
          if (m_nbits <= 8) begin
            m_op = ((m_op << 1) | int'(wr_data[2])) & 8'hFF; m_sdo = 0;
          end else if (m_nbits <= 24) begin
            m_adr = ((m_adr << 1) | int'(wr_data[2])) & 16'hFFFF; m_sdo = 0;
          end else if (m_nbits <= 40) begin
            m_sdo = (m_op == 3) ? ((ref_word(m_adr / 2) >> (40 - m_nbits)) & 1) : 0;
          end else begin
            m_sdo = 0;
          end
        end
        m_sclk = int'(wr_data[0]); m_cs = int'(wr_data[1]);
        m_sdi = int'(wr_data[2]);  m_req = int'(wr_data[4]);
      end else if (wr_en && wr_sel) begin
        m_didx = int'(wr_data[15:8]);
        if (wr_data[0]) begin
          m_ddata = ref_word(m_didx); m_done = 1;
        end else begin
          m_done = 0;
        end
      end
    end
  end

  // compared on every clock
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      n_checks++;
      if (rd_valid !== exp_valid || (exp_valid && rd_data !== exp_data)) begin
        n_fail++;
        $display("FAIL %s: valid=%0b data=%h expected valid=%0b data=%h",
                 tag, rd_valid, rd_data, exp_valid, exp_data);
      end
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // tasks are entered just after a falling edge
  task automatic wr(bit sel, logic [31:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(bit sel, output logic [31:0] d);
    rd_en = 1'b1; rd_sel = sel;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  bit cur_req = 1'b0;

  task automatic ser(bit cs, bit sclk, bit sdi);
    logic [31:0] d;
    d = '0; d[0] = sclk; d[1] = cs; d[2] = sdi; d[4] = cur_req;
    wr(1'b0, d);
  endtask

  task automatic shift_bits(int val, int n, bit glitch);
    for (int k = n - 1; k >= 0; k--) begin
      bit b;
      b = (val >> k) & 1;
      ser(1, 0, b);
      ser(1, 1, b);
      if (glitch) ser(1, 1, ~b); // R3: clock stays high, must not sample
    end
  endtask

  task automatic serial_read(int op, int adr, bit glitch, output int word);
    logic [31:0] d;
    bit q[$];
    shift_bits(op, 8, glitch);
    shift_bits(adr, 16, glitch);
    rd(1'b0, d);
    check("R6", {31'b0, d[3]}, 32'd0);
    for (int k = 0; k < 16; k++) begin
      ser(1, 0, 0);
      ser(1, 1, 0);
      rd(1'b0, d);
      q.push_back(d[3]);
    end
    word = 0;
    foreach (q[k]) word = (word << 1) | int'(q[k]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    tag = "R1";
    rd(1'b0, d); check("R1", d, 32'd0);
    rd(1'b1, d); check("R1", d, 32'd0);

    tag = "R9";
    wr(1'b1, {16'h0, 8'd5, 7'b0, 1'b1});
    rd(1'b1, d); check("R9", d, {16'(ref_word(5)), 8'd5, 6'b0, 1'b1, 1'b0});
    check("R11", {16'h0, d[31:16]}, 32'h0000A0C6);
    wr(1'b1, {16'h0, 8'd63, 7'b0, 1'b1});
    rd(1'b1, d); check("R9", d, {16'(ref_word(63)), 8'd63, 6'b0, 1'b1, 1'b0});
    wr(1'b1, {16'h0, 8'd64, 7'b0, 1'b1});
    rd(1'b1, d); check("R9", d, {16'h0, 8'd64, 6'b0, 1'b1, 1'b0});
    wr(1'b1, {16'h0, 8'd9, 7'b0, 1'b1});
    tag = "R10";
    wr(1'b1, {16'hFFFF, 8'd7, 7'b0, 1'b0});
    rd(1'b1, d); check("R10", d, {16'(ref_word(9)), 8'd7, 6'b0, 1'b0, 1'b0});

    tag = "R8";
    cur_req = 1'b1; ser(0, 0, 0);
    rd(1'b0, d); check("R8", {30'b0, d[5], d[4]}, 32'd3);
    cur_req = 1'b0; ser(0, 0, 0);
    rd(1'b0, d); check("R8", {30'b0, d[5], d[4]}, 32'd0);
    cur_req = 1'b1;

    tag = "R5";
    serial_read(3, 16'h000A, 0, w); check("R5", w, ref_word(5));
    ser(1, 0, 0); ser(1, 1, 0);
    rd(1'b0, d); check("R5", {31'b0, d[3]}, 32'd0);
    ser(0, 0, 0);
    serial_read(3, 16'h000B, 0, w); check("R5", w, ref_word(5));
    ser(0, 0, 0);
    serial_read(3, 16'h007F, 0, w); check("R5", w, ref_word(63));
    ser(0, 0, 0);
    serial_read(3, 16'h0080, 0, w); check("R5", w, 0);
    ser(0, 0, 0);

    tag = "R4";
    serial_read(8'h0B, 16'h0010, 0, w); check("R4", w, 0);
    ser(0, 0, 0);
    serial_read(3, 16'h0046, 0, w); check("R4", w, ref_word(35));
    ser(0, 0, 0);

    tag = "R3";
    serial_read(3, 16'h0020, 1, w); check("R3", w, ref_word(16));
    ser(0, 0, 0);

    tag = "R7";
    shift_bits(8'h5A, 5, 0);
    ser(0, 0, 0);
    rd(1'b0, d); check("R7", {31'b0, d[3]}, 32'd0);
    ser(0, 1, 1); // rising clock with select low is not sampled
    ser(0, 0, 0);
    serial_read(3, 16'h0002, 0, w); check("R7", w, ref_word(1));
    ser(0, 0, 0);

    tag = "R2";
    rd_en = 1'b1; rd_sel = 1'b1;
    @(negedge clk);
    rd_sel = 1'b0;
    @(negedge clk);
    rd_en = 1'b0;
    repeat (2) @(negedge clk);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule